// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a host-driven SPI master that runs one flash command each time software sets its start bit. Software places the command byte in a dedicated opcode register and the byte counts in a packed count register. It loads any bytes that follow the opcode into a small circular buffer through a single data port, then sets the start bit. The engine lowers chip select and shifts out the opcode, then the queued bytes. It then clocks in the requested number of response bytes and stores them in the same buffer, directly after the bytes that were sent.

The buffer has eight entries and one pointer. Each data-port access moves the pointer by one, and the pointer wraps after the last entry. Software can read the pointer and can clear it through the control register. To collect a response, software clears the pointer, reads the port once for each byte it sent in order to skip those bytes, and then reads the response bytes.

When a command has no bytes after the opcode, the engine still clocks in the full programmed read count but does not store the last byte. The register bus is a plain single-cycle strobe interface: every access completes in the cycle it is presented and is never stalled. It carries no valid/ready flow control, so there are no back-pressure rules.

Top module: `spi_cmd_engine`

## Requirements
- R1: The byte in the opcode register (address 0x0) is the first byte shifted out on MOSI. It is sent MSB first and is never taken from the buffer.
- R2: The count register (address 0x1) holds the read count in bits [7:4] and the write count in bits [3:0]. It reads back unchanged after a command.
- R3: Writing 1 to bit 0 of the control register (address 0x2) starts a command. Bit 0 reads 1 while the command runs and returns to 0 by itself when the command ends.
- R4: Each read or write of the data port (address 0xC) accesses the buffer entry at the pointer and advances the pointer by one, modulo 8. Bits [2:0] of address 0xD return the pointer.
- R5: Writing 1 to bit 4 of the control register sets the pointer to 0 in the next cycle. Bit 4 always reads 0.
- R6: A command sends the bytes in buffer entries 0 to wr-1 after the opcode, then stores response bytes in the entries that follow. The pointer ends at (wr + stored) mod 8, and the host reads the responses back after skipping wr entries.
- R7: When the write count is 0 and the read count is nonzero, all programmed read bytes are clocked but the last one is not stored, so stored = rd - 1. Otherwise stored = rd.
- R8: The serial link uses SPI mode 0 with SCK at one quarter of the clock rate, and SCK is low whenever chip select is high. Chip select is low for the whole command, which shifts (1 + wr + rd) bytes in total.
- R9: While a command runs, writes to the opcode register, the count register and the data port are ignored. Data-port reads return 0 and do not move the pointer.
- R10: After reset, chip select is high, SCK is low, the pointer is 0, and the count and control registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances the pointer on the data port) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, valid in the same cycle as the read strobe |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Two events can fall in the same cycle.

The first pair is a pointer clear and a command start: a single control write with both bits set requests both. The bench issues that write and judges the result by the command's output. The first byte after the opcode must be entry 0, and the final pointer must match (wr + stored) mod 8.

The second pair is a host access to the data port and the engine's own buffer traffic, which can coincide while a command runs. The bench writes and reads the port in mid-command and writes new counts and a new opcode. It then checks that the port read returned 0, the response bytes are intact, the final pointer is unchanged, and the count register holds its original value.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BUF_DEPTH = 8;
  localparam int PTR_W     = $clog2(BUF_DEPTH);
  localparam int CNT_W     = 4;

  localparam logic [3:0] ADR_OPCODE = 4'h0;
  localparam logic [3:0] ADR_COUNTS = 4'h1;
  localparam logic [3:0] ADR_CTRL   = 4'h2;
  localparam logic [3:0] ADR_PORT   = 4'hC;
  localparam logic [3:0] ADR_PTR    = 4'hD;

  localparam int CTRL_GO_BIT  = 0;
  localparam int CTRL_CLR_BIT = 4;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LAUNCH,
    SQ_SHIFT
  } sq_state_t;

  typedef enum logic [1:0] {
    BK_OPCODE,
    BK_SEND,
    BK_RECV
  } byte_kind_t;
endpackage

// File: rtl/spi_data_buf.sv
module spi_data_buf #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] ptr
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr_nxt;

  assign ptr_nxt = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + AW'(1);
  assign rdata   = mem[ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (clr) begin
      ptr <= '0;
    end else if (adv || wr_en) begin
      ptr <= ptr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && !clr) begin
      mem[ptr] <= wdata;
    end
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int CLK_DIV = 4,
  localparam int PH_W   = $clog2(CLK_DIV),
  localparam int HALF   = CLK_DIV / 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);

  logic            active;
  logic [PH_W-1:0] phase;
  logic [2:0]      bitn;
  logic [7:0]      tx_sh;
  logic [7:0]      rx_sh;
  logic            bit_end;

  assign bit_end = active && (phase == PH_LAST);
  assign done    = bit_end && (bitn == 3'd7);
  assign rx      = {rx_sh[6:0], miso};
  assign sck     = active && (phase >= PH_HALF);
  assign mosi    = tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= '0;
      bitn   <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (start) begin
      active <= 1'b1;
      phase  <= '0;
      bitn   <= '0;
      tx_sh  <= tx;
    end else if (active) begin
      if (bit_end) begin
        phase <= '0;
        rx_sh <= {rx_sh[6:0], miso};
        tx_sh <= {tx_sh[6:0], 1'b0};
        bitn  <= bitn + 3'd1;
        if (bitn == 3'd7) active <= 1'b0;
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [7:0]       opcode,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [CNT_W-1:0] rd_cnt,
  input  logic [7:0]       buf_rdata,
  input  logic             sh_done,
  input  logic [7:0]       sh_rx,
  output logic             busy,
  output logic             cs_n,
  output logic             buf_clr,
  output logic             buf_adv,
  output logic             buf_wr,
  output logic [7:0]       buf_wdata,
  output logic             sh_start,
  output logic [7:0]       sh_tx
);
  sq_state_t        state;
  byte_kind_t       kind;
  logic [CNT_W-1:0] idx;
  logic             last_send;
  logic             last_recv;
  logic             drop_last;

  assign busy      = (state != SQ_IDLE);
  assign cs_n      = (state == SQ_IDLE);
  assign last_send = (idx == wr_cnt - CNT_W'(1));
  assign last_recv = (idx == rd_cnt - CNT_W'(1));
  assign drop_last = (wr_cnt == '0) && last_recv;

  always_comb begin
    buf_clr   = (state == SQ_IDLE) && go;
    sh_start  = (state == SQ_LAUNCH);
    buf_adv   = 1'b0;
    buf_wr    = 1'b0;
    buf_wdata = sh_rx;
    case (kind)
      BK_OPCODE: sh_tx = opcode;
      BK_SEND:   sh_tx = buf_rdata;
      default:   sh_tx = 8'h00;
    endcase
    if ((state == SQ_SHIFT) && sh_done) begin
      buf_adv = (kind == BK_SEND);
      buf_wr  = (kind == BK_RECV) && !drop_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      kind  <= BK_OPCODE;
      idx   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (go) begin
            state <= SQ_LAUNCH;
            kind  <= BK_OPCODE;
            idx   <= '0;
          end
        end
        SQ_LAUNCH: state <= SQ_SHIFT;
        SQ_SHIFT: begin
          if (sh_done) begin
            idx <= idx + CNT_W'(1);
            unique case (kind)
              BK_OPCODE: begin
                idx <= '0;
                if (wr_cnt != '0) begin
                  kind  <= BK_SEND;
                  state <= SQ_LAUNCH;
                end else if (rd_cnt != '0) begin
                  kind  <= BK_RECV;
                  state <= SQ_LAUNCH;
                end else begin
                  state <= SQ_IDLE;
                end
              end
              BK_SEND: begin
                if (last_send) begin
                  idx <= '0;
                  if (rd_cnt != '0) begin
                    kind  <= BK_RECV;
                    state <= SQ_LAUNCH;
                  end else begin
                    state <= SQ_IDLE;
                  end
                end else begin
                  state <= SQ_LAUNCH;
                end
              end
              default: begin
                state <= last_recv ? SQ_IDLE : SQ_LAUNCH;
              end
            endcase
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic [7:0]       opcode_q;
  logic [7:0]       cnt_q;
  logic             busy;
  logic [PTR_W-1:0] fifo_ptr;
  logic [7:0]       fifo_rdata;

  logic host_port_wr, host_port_rd, host_go, host_clr;
  logic seq_clr, seq_adv, seq_wr;
  logic [7:0] seq_wdata;
  logic sh_start, sh_done;
  logic [7:0] sh_tx, sh_rx;

  assign host_port_wr = bus_wr && (bus_addr == ADR_PORT) && !busy;
  assign host_port_rd = bus_rd && (bus_addr == ADR_PORT) && !busy;
  assign host_go      = bus_wr && (bus_addr == ADR_CTRL) && bus_wdata[CTRL_GO_BIT] && !busy;
  assign host_clr     = bus_wr && (bus_addr == ADR_CTRL) && bus_wdata[CTRL_CLR_BIT] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= '0;
      cnt_q    <= '0;
    end else if (bus_wr && !busy) begin
      if (bus_addr == ADR_OPCODE) opcode_q <= bus_wdata;
      if (bus_addr == ADR_COUNTS) cnt_q    <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_OPCODE: bus_rdata = opcode_q;
      ADR_COUNTS: bus_rdata = cnt_q;
      ADR_CTRL:   bus_rdata = {7'b0, busy};
      ADR_PORT:   bus_rdata = busy ? 8'h00 : fifo_rdata;
      ADR_PTR:    bus_rdata = {{(8-PTR_W){1'b0}}, fifo_ptr};
      default:    bus_rdata = 8'h00;
    endcase
  end

  spi_data_buf #(.DEPTH(BUF_DEPTH), .DW(8)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (host_clr || seq_clr),
    .adv   (host_port_rd || seq_adv),
    .wr_en (host_port_wr || seq_wr),
    .wdata (busy ? seq_wdata : bus_wdata),
    .rdata (fifo_rdata),
    .ptr   (fifo_ptr)
  );

  spi_cmd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (host_go),
    .opcode    (opcode_q),
    .wr_cnt    (cnt_q[CNT_W-1:0]),
    .rd_cnt    (cnt_q[2*CNT_W-1:CNT_W]),
    .buf_rdata (fifo_rdata),
    .sh_done   (sh_done),
    .sh_rx     (sh_rx),
    .busy      (busy),
    .cs_n      (spi_cs_n),
    .buf_clr   (seq_clr),
    .buf_adv   (seq_adv),
    .buf_wr    (seq_wr),
    .buf_wdata (seq_wdata),
    .sh_start  (sh_start),
    .sh_tx     (sh_tx)
  );

  spi_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sh_start),
    .tx    (sh_tx),
    .miso  (spi_miso),
    .sck   (spi_sck),
    .mosi  (spi_mosi),
    .done  (sh_done),
    .rx    (sh_rx)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk
  import spi_cmd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [3:0]       bus_addr,
  input logic             go_bit,
  input logic             clr_bit,
  input logic [7:0]       cnt_q,
  input logic [PTR_W-1:0] ptr,
  input logic             spi_cs_n,
  input logic             spi_sck
);
  // R8: no serial clock activity outside chip select
  a_r8_sck_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R8: each high phase of SCK lasts more than one cycle
  a_r8_sck_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |=> spi_sck);

  // R3: an accepted start raises the busy bit
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_CTRL && go_bit && !busy) |=> busy);

  // R2, R9: count register survives writes during a command
  a_r9_cnt_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == ADR_COUNTS) |=> $stable(cnt_q));

  // R4: idle data-port access moves the pointer by one
  a_r4_port_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (bus_wr || bus_rd) && bus_addr == ADR_PORT)
      |=> ptr == $past(ptr) + PTR_W'(1));

  // R5: pointer clear lands in the next cycle
  a_r5_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_wr && bus_addr == ADR_CTRL && clr_bit) |=> ptr == '0);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .go_bit   (bus_wdata[0]),
  .clr_bit  (bus_wdata[4]),
  .cnt_q    (cnt_q),
  .ptr      (fifo_ptr),
  .spi_cs_n (spi_cs_n),
  .spi_sck  (spi_sck)
);

// File: tb/spi_cmd_engine_tb.sv
module spi_cmd_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 1729;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       spi_sck, spi_cs_n, spi_mosi;
  logic       spi_miso = 1'b0;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [7:0] stream [32];
  logic [7:0] mosi_b [32];
  logic [7:0] wdat [16];
  int bitpos = 0;
  int rises_cs_high = 0;
  realtime rise_t0, rise_t1;

  spi_cmd_engine #(.CLK_DIV(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // flash model: mode 0, shifts on falling SCK
  always @(negedge spi_cs_n) begin
    bitpos = 0;
    spi_miso = stream[0][7];
  end
  always @(posedge spi_sck) begin
    if (spi_cs_n) rises_cs_high++;
    else if (bitpos < 256) begin
      mosi_b[bitpos/8][7-(bitpos%8)] = spi_mosi;
      if (bitpos == 0) rise_t0 = $realtime;
      if (bitpos == 1) rise_t1 = $realtime;
      bitpos++;
    end
  end
  always @(negedge spi_sck) begin
    if (!spi_cs_n && bitpos < 256) spi_miso = stream[bitpos/8][7-(bitpos%8)];
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #(CLK_PERIOD/4);
    d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic int stored_cnt(int wr, int rd);
    return (wr == 0 && rd > 0) ? rd - 1 : rd;
  endfunction

  function automatic int end_ptr(int wr, int rd);
    return (wr + stored_cnt(wr, rd)) % 8;
  endfunction

  task automatic run_cmd(logic [7:0] op, int wr, int rd, bit poke);
    logic [7:0] v;
    int n;
    wr_reg(4'h0, op);
    wr_reg(4'h1, {4'(rd), 4'(wr)});
    wr_reg(4'h2, 8'h10);
    for (int i = 0; i < wr; i++) begin
      wdat[i] = 8'($urandom);
      wr_reg(4'hC, wdat[i]);
    end
    rd_reg(4'hD, v);
    check("R4 pointer after fill", int'(v[2:0]), wr % 8);
    for (int i = 0; i < 32; i++) stream[i] = 8'($urandom);
    // R5 + start in one write
    wr_reg(4'h2, 8'h11);
    rd_reg(4'h2, v);
    check("R3 busy set", int'(v), 1);
    if (poke) begin
      wr_reg(4'hC, 8'hA5);
      wr_reg(4'h1, 8'hFF);
      wr_reg(4'h0, 8'h3C);
      rd_reg(4'hC, v);
      check("R9 port read while busy", int'(v), 0);
    end
    n = 0;
    do begin
      rd_reg(4'h2, v);
      n++;
    end while (v[0] && n < 4000);
    check("R3 busy cleared", int'(v), 0);
    check("R8 cs high at end", int'(spi_cs_n), 1);
    check("R8 bits shifted", bitpos, 8 * (1 + wr + rd));
    check("R8 sck period", int'((rise_t1 - rise_t0) / CLK_PERIOD), 4);
    check("R1 opcode first", int'(mosi_b[0]), int'(op));
    for (int i = 0; i < wr; i++)
      check("R6 sent byte", int'(mosi_b[1+i]), int'(wdat[i]));
    rd_reg(4'hD, v);
    check((wr == 0) ? "R7 pointer opcode-only" : "R6 end pointer",
          int'(v[2:0]), end_ptr(wr, rd));
    rd_reg(4'h1, v);
    check("R2 counts retained", int'(v), (rd << 4) | wr);
    rd_reg(4'h0, v);
    check("R9 opcode retained", int'(v), int'(op));
    if (wr + stored_cnt(wr, rd) <= 8) begin
      wr_reg(4'h2, 8'h10);
      for (int i = 0; i < wr; i++) begin
        rd_reg(4'hC, v);
        check("R6 skip entry", int'(v), int'(wdat[i]));
      end
      for (int i = 0; i < stored_cnt(wr, rd); i++) begin
        rd_reg(4'hC, v);
        check((wr == 0) ? "R7 response" : "R6 response",
              int'(v), int'(stream[1+wr+i]));
      end
    end
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] b [10];
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 cs_n", int'(spi_cs_n), 1);
    check("R10 sck", int'(spi_sck), 0);
    rd_reg(4'hD, v); check("R10 pointer", int'(v), 0);
    rd_reg(4'h1, v); check("R10 counts", int'(v), 0);
    rd_reg(4'h2, v); check("R10 ctrl", int'(v), 0);

    // R4 wrap: ten writes land the pointer at 2 and overwrite entries 0,1
    for (int i = 0; i < 10; i++) begin
      b[i] = 8'(8'h30 + i);
      wr_reg(4'hC, b[i]);
    end
    rd_reg(4'hD, v); check("R4 wrap pointer", int'(v), 2);
    // R5 clear and readback of bit 4
    wr_reg(4'h2, 8'h10);
    rd_reg(4'hD, v); check("R5 pointer cleared", int'(v), 0);
    rd_reg(4'h2, v); check("R5 clear bit reads 0", int'(v), 0);
    rd_reg(4'hC, v); check("R4 entry0", int'(v), int'(b[8]));
    rd_reg(4'hC, v); check("R4 entry1", int'(v), int'(b[9]));
    rd_reg(4'hC, v); check("R4 entry2", int'(v), int'(b[2]));
    rd_reg(4'hD, v); check("R4 pointer after reads", int'(v), 3);

    // directed corners
    run_cmd(8'h9F, 0, 0, 1'b0);
    run_cmd(8'h05, 0, 1, 1'b0);
    run_cmd(8'hAB, 0, 4, 1'b0);
    run_cmd(8'h03, 4, 4, 1'b0);
    run_cmd(8'h02, 8, 0, 1'b0);
    run_cmd(8'h0B, 5, 7, 1'b0);
    run_cmd(8'hD8, 3, 3, 1'b1);
    // random commands
    for (int k = 0; k < 30; k++) begin
      int wr, rd;
      wr = int'($urandom % 6);
      rd = int'($urandom % (9 - wr));
      run_cmd(8'($urandom), wr, rd, ($urandom % 4) == 0);
    end
    check("R8 no sck while cs high", rises_cs_high, 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule